// File: doc/BRIEF.md
# Disk sector read sequencer

This block times the read of one sector on a hard-sectored disk drive. The drive supplies index, sector, servo clock, read clock and read data lines, all asynchronous to the system clock. For each sector, the block takes four counts from a command queue: a first gap, an address field length, a second gap and a data field length. It waits out each gap by counting servo clock cycles. It raises a read-enable output for the two fields only.

Within a field, the block first waits for the read data line to go high, which marks the sync bit. It then takes one bit for each high period of the read clock and packs the bits into words for a receive queue. After the data field it waits for the next sector pulse and starts again with fresh counts. The very first sequence after reset starts only once the index line has been seen high.

Top module: `sector_read_seq`

## Requirements
- R1: After reset, phase reads 0 (idle), read enable is low, and no command is popped until the index input has been seen high. Servo pulses during this wait have no effect.
- R2: A gap count of N lasts exactly N+1 servo clock cycles. One cycle is a high level followed by a low level. Read enable stays low throughout the gap.
- R3: The phase output encodes the sequence as idle=0, gap A=1, address=2, gap B=3, data=4 and wait-sector=5. Commands are consumed in this order: gap A count, address length, gap B count, data length.
- R4: After read enable rises for a field, read clock pulses taken while read data is low capture nothing. Capture starts once read data has been high, and that sync-bit level is the first bit sampled.
- R5: A field length of N captures exactly N+1 bits. Each bit is taken once per high period of the read clock. Read enable stays high until the last bit and falls after it.
- R6: Read enable is high only in the address and data phases. Read clock pulses outside a field, including during gap B, capture nothing.
- R7: Bits enter a WORD_W-bit (32) shift register with the earliest bit most significant. Each full word is pushed with rxCount=32. A partial word at the end of a field is pushed right-aligned in the low rxCount bits. Each field starts a new word.
- R8: When a count is needed and the command queue is empty, the block stalls in its current phase with read enable low. Servo pulses during the stall do not count toward the gap.
- R9: If rxFull is high when a word is ready, the word is dropped, rxPush stays low and overflow becomes 1. Overflow stays set until reset.
- R10: After the data field the block holds phase 5 without popping commands until the sector input goes high. It then restarts at gap A with the next counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| indexIn | input | 1 | Drive index line (asynchronous) |
| sectorIn | input | 1 | Drive sector pulse (asynchronous) |
| servoClkIn | input | 1 | Drive servo clock used to time the gaps |
| readClkIn | input | 1 | Drive read clock used to sample bits |
| readDataIn | input | 1 | Drive serial read data |
| cmdValid | input | 1 | Command queue holds a count |
| cmdData | input | CNT_W | Count at the head of the command queue |
| cmdPop | output | 1 | Removes the head count this cycle |
| readEn | output | 1 | Read enable to the drive |
| rxWord | output | WORD_W | Packed captured bits |
| rxCount | output | $clog2(WORD_W+1) | Number of valid bits in rxWord |
| rxPush | output | 1 | Writes rxWord and rxCount into the receive queue |
| rxFull | input | 1 | Receive queue cannot accept a word |
| overflow | output | 1 | Sticky flag for a dropped word |
| phase | output | 3 | Current phase code |

## Verification
The hardest case to reach is the one where the gap counter must ignore servo pulses that arrive while it is stalled on an empty command queue, and then count exactly N+1 fresh cycles. The bench reaches it by raising the sector pulse with no counts queued. It then drives servo pulses and only afterwards supplies the counts. It checks that read enable is still low after N pulses and high after one more. The bench builds every drive waveform level by level. This lets it sweep gap and field lengths across the word boundaries (1, 8, 32 and 33 bits, and others) and compute each expected word arithmetically.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_GAPA = 3'd1,
    PH_ADDR = 3'd2,
    PH_GAPB = 3'd3,
    PH_DATA = 3'd4,
    PH_WSEC = 3'd5
  } phase_e;

  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic sample;
    logic last;
  } ctlStrobes_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        indexS,
  input  logic        sectorS,
  input  logic        servoS,
  input  logic        readClkS,
  input  logic        readDataS,
  input  logic        cmdValid,
  input  logic        cntZero,
  output logic        cmdPop,
  output logic        readEn,
  output logic [2:0]  phase,
  output ctlStrobes_t strobes
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_POPA, ST_GAPA, ST_POPADR, ST_SYNCA, ST_ADR,
    ST_POPB, ST_GAPB, ST_POPD, ST_SYNCD, ST_DAT, ST_WSEC
  } state_e;

  state_e state, stateNext;
  logic   armed, armedNext;
  logic   servoPrev, servoFall;

  assign servoFall = servoPrev & ~servoS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      armed     <= 1'b0;
      servoPrev <= 1'b0;
    end else begin
      state     <= stateNext;
      armed     <= armedNext;
      servoPrev <= servoS;
    end
  end

  always_comb begin
    stateNext = state;
    armedNext = armed;
    strobes   = '0;
    cmdPop    = 1'b0;
    unique case (state)
      ST_IDLE: if (indexS) stateNext = ST_POPA;
      ST_POPA, ST_POPADR, ST_POPB, ST_POPD: begin
        if (cmdValid) begin
          cmdPop          = 1'b1;
          strobes.cntLoad = 1'b1;
          unique case (state)
            ST_POPA:   stateNext = ST_GAPA;
            ST_POPADR: stateNext = ST_SYNCA;
            ST_POPB:   stateNext = ST_GAPB;
            default:   stateNext = ST_SYNCD;
          endcase
        end
      end
      ST_GAPA, ST_GAPB: begin
        if (servoFall) begin
          if (cntZero) stateNext = (state == ST_GAPA) ? ST_POPADR : ST_POPD;
          else         strobes.cntDec = 1'b1;
        end
      end
      ST_SYNCA, ST_SYNCD: begin
        if (readDataS) begin
          stateNext = (state == ST_SYNCA) ? ST_ADR : ST_DAT;
          armedNext = 1'b1;
        end
      end
      ST_ADR, ST_DAT: begin
        if (readClkS && armed) begin
          strobes.sample = 1'b1;
          armedNext      = 1'b0;
          if (cntZero) begin
            strobes.last = 1'b1;
            stateNext    = (state == ST_ADR) ? ST_POPB : ST_WSEC;
          end else begin
            strobes.cntDec = 1'b1;
          end
        end else if (!readClkS) begin
          armedNext = 1'b1;
        end
      end
      default: if (sectorS) stateNext = ST_POPA;
    endcase
  end

  assign readEn = (state == ST_SYNCA) || (state == ST_ADR) ||
                  (state == ST_SYNCD) || (state == ST_DAT);

  always_comb begin
    unique case (state)
      ST_IDLE:                      phase = PH_IDLE;
      ST_POPA, ST_GAPA:             phase = PH_GAPA;
      ST_POPADR, ST_SYNCA, ST_ADR:  phase = PH_ADDR;
      ST_POPB, ST_GAPB:             phase = PH_GAPB;
      ST_POPD, ST_SYNCD, ST_DAT:    phase = PH_DATA;
      default:                      phase = PH_WSEC;
    endcase
  end

  AST_DEC_NOT_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntDec |-> !cntZero); // R2
  AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sample |=> !strobes.sample); // R5
  AST_RE_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobes.last |=> !readEn); // R6
  AST_POP_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    cmdPop |-> (cmdValid && !readEn)); // R8
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32,
  parameter int BC_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [CNT_W-1:0]  cmdData,
  input  logic              readDataS,
  input  logic              rxFull,
  output logic              cntZero,
  output logic [WORD_W-1:0] rxWord,
  output logic [BC_W-1:0]   rxCount,
  output logic              rxPush,
  output logic              overflow
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shiftReg, shiftNext;
  logic [BC_W-1:0]   bitCnt, bitNext;
  logic              flush;

  assign cntZero   = (cnt == '0);
  assign shiftNext = {shiftReg[WORD_W-2:0], readDataS};
  assign bitNext   = bitCnt + 1'b1;
  assign flush     = (bitNext == BC_W'(WORD_W)) || strobes.last;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      shiftReg <= '0;
      bitCnt   <= '0;
      rxWord   <= '0;
      rxCount  <= '0;
      rxPush   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      if (strobes.cntLoad)     cnt <= cmdData;
      else if (strobes.cntDec) cnt <= cnt - 1'b1;
      if (strobes.sample) begin
        if (flush) begin
          shiftReg <= '0;
          bitCnt   <= '0;
          if (rxFull) begin
            overflow <= 1'b1;
          end else begin
            rxPush  <= 1'b1;
            rxWord  <= shiftNext;
            rxCount <= bitNext;
          end
        end else begin
          shiftReg <= shiftNext;
          bitCnt   <= bitNext;
        end
      end
    end
  end

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !$past(rxFull)); // R9
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> (rxCount != '0 && rxCount <= BC_W'(WORD_W))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(overflow) |-> overflow); // R9
endmodule

// File: rtl/sector_read_seq.sv
module sector_read_seq
  import srs_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int BC_W       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              indexIn,
  input  logic              sectorIn,
  input  logic              servoClkIn,
  input  logic              readClkIn,
  input  logic              readDataIn,
  input  logic              cmdValid,
  input  logic [CNT_W-1:0]  cmdData,
  output logic              cmdPop,
  output logic              readEn,
  output logic [WORD_W-1:0] rxWord,
  output logic [BC_W-1:0]   rxCount,
  output logic              rxPush,
  input  logic              rxFull,
  output logic              overflow,
  output logic [2:0]        phase
);
  logic [4:0]  syncVec;
  ctlStrobes_t strobes;
  logic        cntZero;

  srs_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({readDataIn, readClkIn, servoClkIn, sectorIn, indexIn}),
    .syncOut(syncVec)
  );

  srs_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .indexS(syncVec[0]), .sectorS(syncVec[1]), .servoS(syncVec[2]),
    .readClkS(syncVec[3]), .readDataS(syncVec[4]),
    .cmdValid(cmdValid), .cntZero(cntZero),
    .cmdPop(cmdPop), .readEn(readEn), .phase(phase), .strobes(strobes)
  );

  srs_datapath #(.CNT_W(CNT_W), .WORD_W(WORD_W), .BC_W(BC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdData(cmdData),
    .readDataS(syncVec[4]), .rxFull(rxFull), .cntZero(cntZero),
    .rxWord(rxWord), .rxCount(rxCount), .rxPush(rxPush), .overflow(overflow)
  );
endmodule

// File: tb/sim_sector_read_seq.sv
module sim_sector_read_seq;
  localparam int CW = 16;
  localparam int WW = 32;
  localparam int BCW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, indexIn, sectorIn, servoClkIn, readClkIn, readDataIn;
  logic cmdValid, cmdPop, readEn, rxPush, rxFull, overflow;
  logic [CW-1:0] cmdData;
  logic [WW-1:0] rxWord;
  logic [BCW-1:0] rxCount;
  logic [2:0] phase;

  logic [CW-1:0] cmdMem [0:63];
  int cmdWr = 0;
  int cmdRd = 0;
  assign cmdValid = (cmdRd < cmdWr);
  assign cmdData  = cmdMem[cmdRd[5:0]];
  always @(posedge clk) if (cmdPop) cmdRd <= cmdRd + 1;

  logic [WW-1:0] gotW [0:255];
  int gotC [0:255];
  int gotN = 0;
  always @(posedge clk) if (rxPush) begin
    gotW[gotN] <= rxWord;
    gotC[gotN] <= int'(rxCount);
    gotN <= gotN + 1;
  end

  sector_read_seq u0 (
    .clk(clk), .rstN(rstN), .indexIn(indexIn), .sectorIn(sectorIn),
    .servoClkIn(servoClkIn), .readClkIn(readClkIn), .readDataIn(readDataIn),
    .cmdValid(cmdValid), .cmdData(cmdData), .cmdPop(cmdPop), .readEn(readEn),
    .rxWord(rxWord), .rxCount(rxCount), .rxPush(rxPush), .rxFull(rxFull),
    .overflow(overflow), .phase(phase)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic servoPulse();
    servoClkIn = 1'b1; wt(6);
    servoClkIn = 1'b0; wt(6);
  endtask

  task automatic clkBit(logic b);
    readDataIn = b; wt(6);
    readClkIn = 1'b1; wt(6);
    readClkIn = 1'b0;
  endtask

  task automatic pushCmd(int v);
    cmdMem[cmdWr[5:0]] = CW'(v);
    cmdWr++;
  endtask

  task automatic runField(int len, int seed, bit full);
    int base = gotN;
    int expN = 0;
    int cnt = 0;
    logic [WW-1:0] acc = '0;
    for (int k = 0; k <= len; k++) begin
      logic b;
      b = (k == 0) ? 1'b1 : 1'(((k * 5 + seed) >> 2) & 1);
      if (k == len) chk("R5", "readEn before last bit", readEn, 1);
      clkBit(b);
      acc = {acc[WW-2:0], b};
      cnt++;
      if (cnt == WW || k == len) begin
        wt(2);
        if (full) begin
          chk("R9", "no push while full", gotN, base);
        end else begin
          chk("R7", "push count so far", gotN, base + expN + 1);
          chk("R7", "word value", gotW[base + expN], acc);
          chk("R7", "valid bit count", gotC[base + expN], cnt);
        end
        expN++;
        acc = '0;
        cnt = 0;
      end
    end
    readDataIn = 1'b0;
    wt(4);
    chk("R5", "no extra word after field", gotN, full ? base : base + expN);
  endtask

  task automatic runSector(int gA, int aLen, int gB, int dLen, int seed, bit doPush, bit full);
    int n0;
    if (doPush) begin
      pushCmd(gA); pushCmd(aLen); pushCmd(gB); pushCmd(dLen);
    end
    wt(4);
    for (int i = 0; i < gA; i++) servoPulse();
    chk("R2", "readEn after N gap A cycles", readEn, 0);
    chk("R3", "phase in gap A", phase, 1);
    servoPulse();
    wt(2);
    chk("R2", "readEn after N+1 gap A cycles", readEn, 1);
    chk("R3", "phase address", phase, 2);
    n0 = gotN;
    clkBit(1'b0); clkBit(1'b0); wt(40);
    chk("R4", "nothing captured before sync", gotN, n0);
    readDataIn = 1'b1; wt(6);
    runField(aLen, seed, full);
    chk("R6", "readEn low in gap B", readEn, 0);
    chk("R3", "phase gap B", phase, 3);
    n0 = gotN;
    clkBit(1'b1); clkBit(1'b1); readDataIn = 1'b0; wt(40);
    chk("R6", "no capture in gap B", gotN, n0);
    for (int i = 0; i < gB; i++) servoPulse();
    chk("R2", "readEn after N gap B cycles", readEn, 0);
    servoPulse();
    wt(2);
    chk("R2", "readEn after N+1 gap B cycles", readEn, 1);
    chk("R3", "phase data", phase, 4);
    readDataIn = 1'b1; wt(6);
    runField(dLen, seed + 3, full);
    chk("R10", "phase wait sector", phase, 5);
    chk("R6", "readEn low waiting sector", readEn, 0);
  endtask

  task automatic sectorPulse();
    sectorIn = 1'b1; wt(6);
    sectorIn = 1'b0; wt(6);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int rd0;
    rstN = 1'b0; indexIn = 1'b0; sectorIn = 1'b0; servoClkIn = 1'b0;
    readClkIn = 1'b0; readDataIn = 1'b0; rxFull = 1'b0;
    wt(5);
    chk("R1", "reset phase", phase, 0);
    chk("R1", "reset readEn", readEn, 0);
    chk("R9", "reset overflow", overflow, 0);
    chk("R7", "reset rxPush", rxPush, 0);
    rstN = 1'b1;
    wt(4);
    pushCmd(2); pushCmd(0); pushCmd(1); pushCmd(7);
    servoPulse(); servoPulse(); servoPulse();
    chk("R1", "idle before index", phase, 0);
    chk("R1", "no pop before index", cmdRd, 0);
    indexIn = 1'b1; wt(6); indexIn = 1'b0;
    chk("R3", "first count popped", cmdRd, 1);
    runSector(2, 0, 1, 7, 1, 1'b0, 1'b0);
    chk("R3", "four counts consumed", cmdRd, 4);

    for (int s = 0; s < 6; s++) begin
      int aLen;
      case (s % 4)
        0: aLen = 31;
        1: aLen = 32;
        2: aLen = 3;
        default: aLen = 0;
      endcase
      rd0 = cmdRd;
      pushCmd((s % 3) * 2); pushCmd(aLen); pushCmd((s % 2) * 3); pushCmd((s * 13) % 70);
      wt(40);
      chk("R10", "hold until sector", cmdRd, rd0);
      chk("R10", "phase stays wait sector", phase, 5);
      sectorPulse();
      runSector((s % 3) * 2, aLen, (s % 2) * 3, (s * 13) % 70, s, 1'b0, 1'b0);
    end

    sectorPulse();
    wt(50);
    chk("R8", "stall phase gap A", phase, 1);
    chk("R8", "stall readEn low", readEn, 0);
    servoPulse(); servoPulse(); servoPulse();
    chk("R8", "still stalled", phase, 1);
    runSector(4, 5, 0, 63, 9, 1'b1, 1'b0);
    chk("R9", "overflow clear before full", overflow, 0);

    sectorPulse();
    rxFull = 1'b1;
    runSector(1, 40, 0, 2, 4, 1'b1, 1'b1);
    chk("R9", "overflow set", overflow, 1);
    rxFull = 1'b0;
    wt(30);
    chk("R9", "overflow sticky", overflow, 1);
    finishRun();
  end
endmodule